// File: doc/BRIEF.md
# Multi-CPU Interrupt Enable, Mask and Acknowledge Unit

This block is the core of an interrupt controller shared by several CPUs. It watches a vector of level-sensitive request lines and decides, separately for each CPU, which request to present. A shared source reaches a CPU only when four things hold: its line is high, it is globally enabled, its routing map names that CPU, and that CPU has not masked it. A small set of per-CPU sources skips the global enable and the routing map, so only the per-CPU mask gates them. When more than one source qualifies, the lowest source number wins.

Software reaches the block through a simple register port. There are two windows. The global window holds the capability word, the enable set and clear registers, and one routing register per source. The per-CPU window is addressed on behalf of the CPU named on `bus_cpu` and holds that CPU's mask set and clear registers and its acknowledge register. Enable and mask changes are made by writing a source index, not a bitmap. Each CPU gets one interrupt output. Reading the acknowledge register returns the number of the source that this CPU is being shown. The read leaves that source pending, so the request stays asserted until its line drops.

Top module: `irq_route_ctrl`

## Requirements
- R1: After reset every source is globally disabled, masked for every CPU, and has an all-zero routing map. All `cpu_irq` bits are low, every acknowledge read returns 1023, and `bus_rdata` is zero.
- R2: A read of global offset 0x000 returns NUM_SRC in bits [11:2]. All other bits of the word are zero.
- R3: A global write to offset 0x030 sets the enable of the source whose index is in `bus_wdata[9:0]`. A global write to offset 0x034 clears it.
- R4: A per-CPU write to offset 0x048 masks the source indexed by `bus_wdata[9:0]` for the CPU on `bus_cpu`. A per-CPU write to offset 0x04C unmasks it. No other CPU's mask changes.
- R5: The global word at offset 0x100 + 4*n is source n's routing map, with bit c meaning CPU c. Bits [NUM_CPU-1:0] are written and read back, and the upper bits read as zero.
- R6: A shared source is presented to CPU c only when its line is high, it is enabled, bit c of its routing map is set, and it is unmasked for CPU c.
- R7: A source marked in LOCAL_SRC_MAP is gated only by its line and the per-CPU mask. Its enable and routing map have no effect. The default marks sources 3 and 5.
- R8: When several sources qualify for one CPU, the lowest source number is selected.
- R9: A per-CPU read of offset 0x044 returns the selected source number in bits [9:0], or 1023 when none qualifies, and zero in bits [31:10]. Read data appears on `bus_rdata` in the cycle after the read is issued.
- R10: `cpu_irq[c]` is high exactly when some source qualifies for CPU c, lagging the qualifying state by one clock.
- R11: An acknowledge read does not clear a source. The same source is returned again until its line drops.
- R12: A set or clear write whose index is NUM_SRC or larger changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_level | input | NUM_SRC | Level-sensitive request lines |
| bus_sel | input | 1 | Register access this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_percpu | input | 1 | 1 = per-CPU window, 0 = global window |
| bus_cpu | input | CPU_W | CPU on whose behalf a per-CPU access is made |
| bus_addr | input | ADDR_W | Byte offset within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the read |
| cpu_irq | output | NUM_CPU | Interrupt request to each CPU |

## Verification
The assertions rely on the request lines holding a defined value in every cycle. They also rely on a read being a single-cycle pulse of `bus_sel` with `bus_wr` low, so that the word seen one cycle later belongs to that read. The bench drives every input on the falling edge and keeps each access to exactly one cycle. It toggles request lines only between accesses, so every acknowledge word matches the state in force when the read was issued. The random phase also writes indices past the last source, which exercises the ignore rule without breaking these assumptions.

// File: rtl/irq_pkg.sv
package irq_pkg;

    localparam int BUS_W = 32;
    localparam int ID_W  = 10;

    localparam logic [ID_W-1:0] NO_SRC_ID = 10'h3FF;

    localparam logic [31:0] OFS_INFO       = 32'h000;
    localparam logic [31:0] OFS_EN_SET     = 32'h030;
    localparam logic [31:0] OFS_EN_CLR     = 32'h034;
    localparam logic [31:0] OFS_ACK        = 32'h044;
    localparam logic [31:0] OFS_MASK_SET   = 32'h048;
    localparam logic [31:0] OFS_MASK_CLR   = 32'h04C;
    localparam logic [31:0] OFS_ROUTE_BASE = 32'h100;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_EN_SET,
        CMD_EN_CLR,
        CMD_MASK_SET,
        CMD_MASK_CLR,
        CMD_ROUTE_WR
    } cmd_op_e;

    typedef enum logic [1:0] {
        RD_ZERO,
        RD_INFO,
        RD_ROUTE,
        RD_ACK
    } rd_kind_e;

    typedef struct packed {
        logic            hit;
        logic [ID_W-1:0] id;
    } pick_t;

endpackage

// File: rtl/irq_cmd_decode.sv
module irq_cmd_decode
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int ADDR_W  = 12,
    parameter int SRC_W   = 5
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic              bus_percpu,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [BUS_W-1:0]  bus_wdata,
    output cmd_op_e           cmd_op,
    output logic [SRC_W-1:0]  cmd_idx,
    output rd_kind_e          rd_kind,
    output logic [SRC_W-1:0]  rd_idx
);

    localparam logic [31:0] ROUTE_END = OFS_ROUTE_BASE + 32'(4 * NUM_SRC);

    logic [31:0]      addr32;
    logic             in_route;
    logic             idx_ok;
    logic [SRC_W-1:0] route_idx;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^bus_wdata[BUS_W-1:ID_W];

    always_comb begin
        addr32    = 32'(bus_addr);
        in_route  = (addr32 >= OFS_ROUTE_BASE) && (addr32 < ROUTE_END) &&
                    (addr32[1:0] == 2'b00);
        route_idx = SRC_W'((addr32 - OFS_ROUTE_BASE) >> 2);
        idx_ok    = (32'(bus_wdata[ID_W-1:0]) < 32'(NUM_SRC));

        cmd_op  = CMD_NONE;
        cmd_idx = SRC_W'(bus_wdata[ID_W-1:0]);
        rd_kind = RD_ZERO;
        rd_idx  = route_idx;

        if (bus_sel && bus_wr) begin
            if (!bus_percpu) begin
                if (addr32 == OFS_EN_SET && idx_ok) begin
                    cmd_op = CMD_EN_SET;
                end else if (addr32 == OFS_EN_CLR && idx_ok) begin
                    cmd_op = CMD_EN_CLR;
                end else if (in_route) begin
                    cmd_op  = CMD_ROUTE_WR;
                    cmd_idx = route_idx;
                end
            end else begin
                if (addr32 == OFS_MASK_SET && idx_ok) begin
                    cmd_op = CMD_MASK_SET;
                end else if (addr32 == OFS_MASK_CLR && idx_ok) begin
                    cmd_op = CMD_MASK_CLR;
                end
            end
        end else if (bus_sel) begin
            if (!bus_percpu) begin
                if (addr32 == OFS_INFO) begin
                    rd_kind = RD_INFO;
                end else if (in_route) begin
                    rd_kind = RD_ROUTE;
                end
            end else if (addr32 == OFS_ACK) begin
                rd_kind = RD_ACK;
            end
        end
    end

endmodule

// File: rtl/irq_state_regs.sv
module irq_state_regs
    import irq_pkg::*;
#(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int SRC_W   = 5,
    parameter int CPU_W   = 2
) (
    input  logic                              clk,
    input  logic                              rst,
    input  cmd_op_e                           cmd_op,
    input  logic [SRC_W-1:0]                  cmd_idx,
    input  logic [CPU_W-1:0]                  cmd_cpu,
    input  logic [NUM_CPU-1:0]                route_val,
    output logic [NUM_SRC-1:0]                en_q,
    output logic [NUM_CPU-1:0][NUM_SRC-1:0]   mask_q,
    output logic [NUM_SRC-1:0][NUM_CPU-1:0]   route_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= '0;
            mask_q  <= '1;
            route_q <= '0;
        end else begin
            case (cmd_op)
                CMD_EN_SET:   en_q[cmd_idx]            <= 1'b1;
                CMD_EN_CLR:   en_q[cmd_idx]            <= 1'b0;
                CMD_MASK_SET: mask_q[cmd_cpu][cmd_idx] <= 1'b1;
                CMD_MASK_CLR: mask_q[cmd_cpu][cmd_idx] <= 1'b0;
                CMD_ROUTE_WR: route_q[cmd_idx]         <= route_val;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/irq_cpu_select.sv
module irq_cpu_select
    import irq_pkg::*;
#(
    parameter int                 NUM_SRC       = 32,
    parameter logic [NUM_SRC-1:0] LOCAL_SRC_MAP = '0
) (
    input  logic [NUM_SRC-1:0] src_level,
    input  logic [NUM_SRC-1:0] en_q,
    input  logic [NUM_SRC-1:0] mask_row,
    input  logic [NUM_SRC-1:0] route_col,
    output pick_t              pick
);

    logic [NUM_SRC-1:0] qual;

    // shared sources need enable and routing; local ones bypass both
    assign qual = src_level & ~mask_row & (LOCAL_SRC_MAP | (en_q & route_col));

    always_comb begin
        pick.hit = 1'b0;
        pick.id  = NO_SRC_ID;
        for (int n = NUM_SRC - 1; n >= 0; n--) begin
            if (qual[n]) begin
                pick.hit = 1'b1;
                pick.id  = ID_W'(n);
            end
        end
    end

endmodule

// File: rtl/irq_route_ctrl.sv
module irq_route_ctrl
    import irq_pkg::*;
#(
    parameter int                 NUM_SRC       = 32,
    parameter int                 NUM_CPU       = 4,
    parameter int                 ADDR_W        = 12,
    parameter logic [NUM_SRC-1:0] LOCAL_SRC_MAP = NUM_SRC'(6'b101000),
    localparam int                CPU_W         = (NUM_CPU > 1) ? $clog2(NUM_CPU) : 1,
    localparam int                SRC_W         = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_SRC-1:0] src_level,
    input  logic               bus_sel,
    input  logic               bus_wr,
    input  logic               bus_percpu,
    input  logic [CPU_W-1:0]   bus_cpu,
    input  logic [ADDR_W-1:0]  bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic [NUM_CPU-1:0] cpu_irq
);

    cmd_op_e                            cmd_op;
    logic [SRC_W-1:0]                   cmd_idx;
    rd_kind_e                           rd_kind;
    logic [SRC_W-1:0]                   rd_idx;
    logic [NUM_SRC-1:0]                 en_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    mask_q;
    logic [NUM_SRC-1:0][NUM_CPU-1:0]    route_q;
    logic [NUM_CPU-1:0][NUM_SRC-1:0]    route_col;
    pick_t                              picks [NUM_CPU];
    logic [NUM_CPU-1:0]                 hit_vec;
    logic [31:0]                        rd_val;

    irq_cmd_decode #(
        .NUM_SRC (NUM_SRC),
        .ADDR_W  (ADDR_W),
        .SRC_W   (SRC_W)
    ) u_decode (
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_percpu (bus_percpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .cmd_op     (cmd_op),
        .cmd_idx    (cmd_idx),
        .rd_kind    (rd_kind),
        .rd_idx     (rd_idx)
    );

    irq_state_regs #(
        .NUM_SRC (NUM_SRC),
        .NUM_CPU (NUM_CPU),
        .SRC_W   (SRC_W),
        .CPU_W   (CPU_W)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .cmd_op    (cmd_op),
        .cmd_idx   (cmd_idx),
        .cmd_cpu   (bus_cpu),
        .route_val (bus_wdata[NUM_CPU-1:0]),
        .en_q      (en_q),
        .mask_q    (mask_q),
        .route_q   (route_q)
    );

    generate
        for (genvar c = 0; c < NUM_CPU; c++) begin : g_cpu
            for (genvar n = 0; n < NUM_SRC; n++) begin : g_col
                assign route_col[c][n] = route_q[n][c];
            end

            irq_cpu_select #(
                .NUM_SRC       (NUM_SRC),
                .LOCAL_SRC_MAP (LOCAL_SRC_MAP)
            ) u_sel (
                .src_level (src_level),
                .en_q      (en_q),
                .mask_row  (mask_q[c]),
                .route_col (route_col[c]),
                .pick      (picks[c])
            );

            assign hit_vec[c] = picks[c].hit;
        end
    endgenerate

    always_comb begin
        case (rd_kind)
            RD_INFO:  rd_val = 32'(NUM_SRC) << 2;
            RD_ROUTE: rd_val = 32'(route_q[rd_idx]);
            RD_ACK:   rd_val = 32'(picks[bus_cpu].id);
            default:  rd_val = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
            cpu_irq   <= '0;
        end else begin
            bus_rdata <= rd_val;
            cpu_irq   <= hit_vec;
        end
    end

endmodule

// File: rtl/irq_route_ctrl_chk.sv
module irq_route_ctrl_chk #(
    parameter int NUM_SRC = 32,
    parameter int NUM_CPU = 4,
    parameter int ADDR_W  = 12
) (
    input logic               clk,
    input logic               rst,
    input logic [NUM_SRC-1:0] src_level,
    input logic               bus_sel,
    input logic               bus_wr,
    input logic               bus_percpu,
    input logic [ADDR_W-1:0]  bus_addr,
    input logic [31:0]        bus_rdata,
    input logic [NUM_CPU-1:0] cpu_irq
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        $past(rst) |-> (cpu_irq == '0 && bus_rdata == '0));

    // R10
    idle_lines_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(src_level) == '0) |-> cpu_irq == '0);

    // R10
    irq_needs_line_chk: assert property (@(posedge clk) disable iff (rst)
        (cpu_irq != '0) |-> $past(src_level) != '0);

    // R9
    ack_range_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_sel && !bus_wr && bus_percpu &&
                              bus_addr == ADDR_W'('h44)))
        |-> (bus_rdata[31:10] == '0 &&
             (bus_rdata[9:0] == 10'h3FF || 32'(bus_rdata[9:0]) < 32'(NUM_SRC))));

    // R11
    ack_pending_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_sel && !bus_wr && bus_percpu &&
                              bus_addr == ADDR_W'('h44)) &&
         bus_rdata[9:0] != 10'h3FF)
        |-> |(($past(src_level) >> bus_rdata[9:0]) & NUM_SRC'(1)));

    // R2
    info_word_chk: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(bus_sel && !bus_wr && !bus_percpu &&
                              bus_addr == ADDR_W'(0)))
        |-> bus_rdata == (32'(NUM_SRC) << 2));

endmodule

bind irq_route_ctrl irq_route_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_CPU (NUM_CPU),
    .ADDR_W  (ADDR_W)
) u_chk (.*);

// File: tb/irq_route_ctrl_test.sv
`timescale 1ns/1ps
module irq_route_ctrl_test;

    localparam int NS = 8;
    localparam int NC = 4;
    localparam int AW = 12;
    localparam logic [NS-1:0] LOC = 8'h28;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [NS-1:0] src_level = '0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic          bus_percpu = 1'b0;
    logic [1:0]    bus_cpu = '0;
    logic [AW-1:0] bus_addr = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;
    logic [NC-1:0] cpu_irq;

    int n_chk = 0;
    int n_fail = 0;

    bit          m_en [NS];
    bit          m_mask [NC][NS];
    bit [NC-1:0] m_route [NS];
    logic [31:0] rnd = 32'h1234_5678;

    always #10 clk = ~clk;

    irq_route_ctrl #(
        .NUM_SRC       (NS),
        .NUM_CPU       (NC),
        .ADDR_W        (AW),
        .LOCAL_SRC_MAP (LOC)
    ) uut (
        .clk        (clk),
        .rst        (rst),
        .src_level  (src_level),
        .bus_sel    (bus_sel),
        .bus_wr     (bus_wr),
        .bus_percpu (bus_percpu),
        .bus_cpu    (bus_cpu),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_rdata  (bus_rdata),
        .cpu_irq    (cpu_irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic bus_write(input bit pc, input int cpu, input int addr, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_percpu = pc;
        bus_cpu = 2'(cpu); bus_addr = AW'(addr); bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input bit pc, input int cpu, input int addr, output logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_percpu = pc;
        bus_cpu = 2'(cpu); bus_addr = AW'(addr);
        @(negedge clk);
        bus_sel = 1'b0;
        d = bus_rdata;
    endtask

    function automatic int exp_win(input int c);
        for (int n = 0; n < NS; n++) begin
            if (src_level[n] && !m_mask[c][n] &&
                (LOC[n] || (m_en[n] && m_route[n][c])))
                return n;
        end
        return 1023;
    endfunction

    task automatic set_en(input bit on, input int idx);
        bus_write(1'b0, 0, on ? 'h30 : 'h34, 32'(idx));
        if (idx < NS) m_en[idx] = on;
    endtask

    task automatic set_mask(input bit on, input int cpu, input int idx);
        bus_write(1'b1, cpu, on ? 'h48 : 'h4C, 32'(idx));
        if (idx < NS) m_mask[cpu][idx] = on;
    endtask

    task automatic set_route(input int n, input logic [31:0] d);
        bus_write(1'b0, 0, 'h100 + 4 * n, d);
        m_route[n] = d[NC-1:0];
    endtask

    task automatic drive_lines(input logic [NS-1:0] v);
        @(negedge clk);
        src_level = v;
    endtask

    task automatic check_all(input string req);
        logic [31:0] d;
        @(negedge clk);
        for (int c = 0; c < NC; c++) begin
            int e;
            e = exp_win(c);
            chk("R10", int'(cpu_irq[c]), (e != 1023) ? 1 : 0);
            bus_read(1'b1, c, 'h44, d);
            chk(req, int'(d), e);
        end
    endtask

    initial begin
        #(20ns * 150000);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        logic [31:0] d;
        for (int n = 0; n < NS; n++) begin
            m_en[n] = 1'b0;
            m_route[n] = '0;
            for (int c = 0; c < NC; c++) m_mask[c][n] = 1'b1;
        end
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1: outputs quiet, acks empty, routes zero
        chk("R1", int'(cpu_irq), 0);
        chk("R1", int'(bus_rdata), 0);
        drive_lines(8'hFF);
        check_all("R1");
        for (int n = 0; n < NS; n++) begin
            bus_read(1'b0, 0, 'h100 + 4 * n, d);
            chk("R1", int'(d), 0);
        end
        drive_lines(8'h00);

        // R2: capability word
        bus_read(1'b0, 0, 'h000, d);
        chk("R2", int'(d), NS << 2);

        // R5: routing registers, upper write bits dropped
        for (int n = 0; n < NS; n++) begin
            set_route(n, 32'hFFFF_FFF0 | 32'((n * 3 + 1) & 15));
        end
        for (int n = 0; n < NS; n++) begin
            bus_read(1'b0, 0, 'h100 + 4 * n, d);
            chk("R5", int'(d), (n * 3 + 1) & 15);
        end

        // R6: source 6 routed to CPUs 0,1; unmasked on 0 and 2
        drive_lines(8'h40);
        set_en(1'b1, 6);
        set_mask(1'b0, 0, 6);
        set_mask(1'b0, 2, 6);
        check_all("R6");

        // R7: local source 3 without enable, unmasked on CPU 2
        drive_lines(8'h48);
        set_mask(1'b0, 2, 3);
        check_all("R7");

        // R8: CPU 0 sees both 3 and 6, lowest wins
        set_mask(1'b0, 0, 3);
        check_all("R8");

        // R11: repeated acks return the same source until the line drops
        bus_read(1'b1, 0, 'h44, d);
        chk("R11", int'(d), 3);
        bus_read(1'b1, 0, 'h44, d);
        chk("R11", int'(d), 3);
        drive_lines(8'h42);
        check_all("R11");

        // R12: out-of-range index must not alias onto source 1
        set_route(1, 32'h4);
        set_mask(1'b0, 2, 1);
        drive_lines(8'h4A);
        set_en(1'b1, 9);
        set_mask(1'b1, 2, 11);
        check_all("R12");

        // R3: enable then disable source 1
        set_en(1'b1, 1);
        check_all("R3");
        set_en(1'b0, 1);
        check_all("R3");

        // R4: mask on CPU 0 only
        set_mask(1'b1, 0, 3);
        set_mask(1'b1, 0, 6);
        check_all("R4");

        // R9: near-exhaustive pseudo-random sweep
        for (int it = 0; it < 400; it++) begin
            int op, idx, cpu;
            rnd = rnd ^ (rnd << 13);
            rnd = rnd ^ (rnd >> 17);
            rnd = rnd ^ (rnd << 5);
            op  = int'(rnd % 6);
            idx = int'((rnd >> 4) % 16);
            cpu = int'((rnd >> 8) % 4);
            case (op)
                0: set_en(1'b1, idx);
                1: set_en(1'b0, idx);
                2: set_mask(1'b1, cpu, idx);
                3: set_mask(1'b0, cpu, idx);
                4: set_route(idx % NS, rnd >> 12);
                default: drive_lines(src_level ^ rnd[23:16]);
            endcase
            check_all("R9");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule